// File: doc/BRIEF.md
# Eight-Bit Addressable Latch and Demultiplexer

This block holds eight individually writable output bits fed from one serial data input. Three address bits select the target output. An active-low enable and an active-low clear are read together as a two-bit mode. The four modes are:

- **Write one bit:** the addressed output takes the data level.
- **Store:** every output holds.
- **Demultiplex:** the addressed output takes the data level and all others are forced low.
- **Clear:** every output goes low.

All eight outputs are visible in parallel at all times.

The block is built for a clocked fabric. The mode, address and data are sampled on each rising clock edge, and the outputs are registers, so every effect shows up one clock after the inputs that cause it. While the enable is held low in write mode, the addressed bit follows the data from cycle to cycle. When the enable is released, that bit keeps the last data level sampled while the enable was low. A synchronous active-high `rst` brings all outputs to a known low state at start-up. The functional clear input `clr_n` then serves as the mode-level clear during operation.

Top module: `addr_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, all eight outputs are 0 after that edge.
- R2: In write mode (`clr_n`=1, `en_n`=0), the output selected by `addr` takes the value of `din` at the next rising edge.
- R3: In write mode, every output not selected by `addr` keeps its previous value.
- R4: In store mode (`clr_n`=1, `en_n`=1), every output keeps its value whatever `addr` and `din` are.
- R5: In demultiplex mode (`clr_n`=0, `en_n`=0), the selected output takes `din` and every other output becomes 0 at the next edge.
- R6: In clear mode (`clr_n`=0, `en_n`=1), all outputs become 0 regardless of `addr` and `din`.
- R7: After the enable returns high, the previously addressed bit keeps the `din` level sampled on the last edge at which the enable was low. While the enable stays low, that bit follows `din` on each edge.
- R8: Address value k selects output bit `q[k]`, with `addr[0]` as the least significant bit. For example, 0 selects `q[0]` and 7 selects `q[7]`.
- R9: After a clear or demultiplex cycle, a bit that is not addressed afterwards keeps the level that cycle gave it through later store and write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data level for the addressed bit |
| addr | input | 3 | Index of the selected output bit |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear, combined with `en_n` into the mode |
| q | output | 8 | Parallel output bits |

## Verification
The hardest state to reach is a mix of retained and cleared bits. One example is a bit written high, then wiped by a demultiplex cycle aimed elsewhere, then left alone through store and write cycles aimed at other bits. Reaching it from the ports takes an ordered sequence of mode changes, not any single vector.

The stimulus table chains these mode changes back to back. Each vector's expected word depends on every earlier one. Directed tests add a long enable-low window in which `din` toggles before release, a reset pulse in the middle of the run, and a sweep that writes each address alone.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Mode word is {clr_n, en_n}
  typedef enum logic [1:0] {
    MD_DEMUX = 2'b00,
    MD_CLEAR = 2'b01,
    MD_WRITE = 2'b10,
    MD_HOLD  = 2'b11
  } lat_mode_e;

endpackage

// File: rtl/lat_mode_dec.sv
module lat_mode_dec
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              en_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  output lat_mode_e         mode,
  output logic [NBITS-1:0]  sel
);

  always_comb begin
    mode = lat_mode_e'({clr_n, en_n});
  end

  generate
    for (genvar k = 0; k < NBITS; k++) begin : g_sel
      assign sel[k] = (addr == ADDR_W'(k));
    end
  endgenerate

  always_comb begin
    a_sel_onehot_r8 : assert ($onehot(sel) || $isunknown(addr));
  end

endmodule

// File: rtl/lat_bit_cell.sv
module lat_bit_cell
  import addr_latch_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lat_mode_e mode,
  input  logic      sel,
  input  logic      din,
  output logic      q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      unique case (mode)
        MD_WRITE: if (sel) q <= din;
        MD_DEMUX: q <= sel ? din : 1'b0;
        MD_CLEAR: q <= 1'b0;
        default:  q <= q;
      endcase
    end
  end

  p_store_hold_r4 : assert property (@(posedge clk) disable iff (rst)
    (mode == MD_HOLD) |=> $stable(q));

  p_write_sel_r2 : assert property (@(posedge clk) disable iff (rst)
    (mode == MD_WRITE && sel) |=> (q == $past(din)));

endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  input  logic              clr_n,
  output logic [NBITS-1:0]  q
);

  lat_mode_e        mode;
  logic [NBITS-1:0] sel;

  lat_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .en_n  (en_n),
    .clr_n (clr_n),
    .addr  (addr),
    .mode  (mode),
    .sel   (sel)
  );

  generate
    for (genvar k = 0; k < NBITS; k++) begin : g_bit
      lat_bit_cell u_cell (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .sel  (sel[k]),
        .din  (din),
        .q    (q[k])
      );
    end
  endgenerate

  p_reset_low_r1 : assert property (@(posedge clk)
    rst |=> (q == '0));

  p_clear_all_r6 : assert property (@(posedge clk) disable iff (rst)
    (!clr_n && en_n) |=> (q == '0));

  p_demux_single_r5 : assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !en_n) |=> ($countones(q) <= 1));

  p_write_others_r3 : assert property (@(posedge clk) disable iff (rst)
    (clr_n && !en_n) |=>
      (((q ^ $past(q)) & ~(NBITS'(1) << $past(addr))) == '0));

endmodule

// File: tb/addr_latch_tb.sv
module addr_latch_tb;

  localparam int AW = 3;
  localparam int NB = 1 << AW;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          din;
  logic [AW-1:0] addr;
  logic          en_n;
  logic          clr_n;
  logic [NB-1:0] q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_latch #(.ADDR_W(AW)) u_dut (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .addr  (addr),
    .en_n  (en_n),
    .clr_n (clr_n),
    .q     (q)
  );

  // Vector fields: {clr_n, en_n, addr[2:0], din, expected q[7:0], tag[3:0]}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 1'b1, 8'h01, 4'd2},
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h81, 4'd8},
    {1'b1, 1'b0, 3'd3, 1'b1, 8'h89, 4'd3},
    {1'b1, 1'b1, 3'd5, 1'b1, 8'h89, 4'd4},
    {1'b1, 1'b0, 3'd0, 1'b0, 8'h88, 4'd2},
    {1'b1, 1'b0, 3'd5, 1'b1, 8'hA8, 4'd3},
    {1'b1, 1'b1, 3'd2, 1'b0, 8'hA8, 4'd4},
    {1'b0, 1'b0, 3'd6, 1'b1, 8'h40, 4'd5},
    {1'b1, 1'b1, 3'd1, 1'b1, 8'h40, 4'd9},
    {1'b1, 1'b0, 3'd1, 1'b1, 8'h42, 4'd9},
    {1'b0, 1'b0, 3'd1, 1'b0, 8'h00, 4'd5},
    {1'b1, 1'b0, 3'd4, 1'b1, 8'h10, 4'd9},
    {1'b0, 1'b1, 3'd4, 1'b1, 8'h00, 4'd6},
    {1'b1, 1'b0, 3'd2, 1'b1, 8'h04, 4'd2},
    {1'b1, 1'b0, 3'd2, 1'b0, 8'h00, 4'd7},
    {1'b1, 1'b0, 3'd2, 1'b1, 8'h04, 4'd7}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [NB-1:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected=%h", req, q, exp);
    end
  endtask

  // Inputs change on the falling edge; the result is sampled at the next falling edge.
  task automatic step(input logic c, input logic e, input logic [AW-1:0] a, input logic d);
    @(negedge clk);
    clr_n = c; en_n = e; addr = a; din = d;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: q=%h expected=done", q);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; din = 1'b0; addr = '0; en_n = 1'b1; clr_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][17], VEC[i][16], VEC[i][15:13], VEC[i][12]);
      check(tag_name(VEC[i][3:0]), VEC[i][11:4]);
    end

    // R7: the addressed bit follows din while enabled, then keeps the last sample
    step(1'b1, 1'b1, 3'd6, 1'b0);
    step(1'b1, 1'b0, 3'd6, 1'b1);
    check("R7", 8'h44);
    step(1'b1, 1'b0, 3'd6, 1'b0);
    check("R7", 8'h04);
    step(1'b1, 1'b0, 3'd6, 1'b1);
    step(1'b1, 1'b1, 3'd6, 1'b0);
    check("R7", 8'h44);
    step(1'b1, 1'b1, 3'd0, 1'b1);
    check("R4", 8'h44);

    // R1: a reset pulse in the middle of the run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", 8'h00);

    // R8: each address on its own selects exactly its own bit
    for (int k = 0; k < NB; k++) begin
      step(1'b0, 1'b1, 3'd0, 1'b0);
      step(1'b1, 1'b0, AW'(k), 1'b1);
      check("R8", NB'(1) << k);
    end

    // R5 and R9: demux to the high bit, then store and write elsewhere
    step(1'b0, 1'b0, 3'd7, 1'b1);
    check("R5", 8'h80);
    step(1'b1, 1'b1, 3'd3, 1'b1);
    step(1'b1, 1'b0, 3'd0, 1'b1);
    check("R9", 8'h81);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule